// File: doc/BRIEF.md
# Glitch-Free Gated Clock Distributor

This block hands out nine gated copies of one reference clock. Each copy runs only when two enables agree: a hardware enable pin and a software enable bit. There are six hardware pins. Four of them each serve a single output. A fifth pin serves a pair of outputs, and the sixth serves a trio. Every start and stop happens on a whole cycle boundary. A stopped copy rests low, and no high phase is ever cut short or stretched.

A single asynchronous input carries two meanings. After reset it qualifies power-good. While it is still low in that phase, the clock outputs stay off, but the status flags keep the oscillator and the serial control logic running. The first time the input is sampled high, a sticky flag arms. From then on the same input acts as an active-low power-down. Pulling it low stops every output and drops both run flags. Raising it again restarts each output whose own enables are high.

Top module: `clk_gate_ctrl`

## Requirements
- R1: While reset is held and in the cycles after it is released with the power input low, every clock output is low and both run flags (`osc_run`, `ser_run`) are high.
- R2: Output i toggles with the reference clock only when `sw_oe[i]` and its hardware pin are both high; with either low, the output makes no pulses.
- R3: Pins are mapped to outputs as follows: `hw_oe[0..3]` drive outputs 0..3 one to one, `hw_oe[4]` drives outputs 4 and 5, and `hw_oe[5]` drives outputs 6, 7 and 8. Lowering one pin affects only its own outputs.
- R4: Every high pulse on an output lasts exactly one reference high phase, and a stopped output reads low while the reference clock is high.
- R5: After a hardware pin rises, the first rising edge on its outputs comes no sooner than 2 and no later than 6 reference cycles later.
- R6: Before the power input has first been sampled high, all outputs are off and both run flags stay high. The first high sample arms the power-down meaning.
- R7: Once armed, a low power input stops all outputs and drops both run flags within 3 reference cycles.
- R8: Once armed, a rising edge on the power input raises both run flags and restarts enabled outputs within 2 to 6 reference cycles, glitch-free.
- R9: The armed state is cleared only by reset. A second power-down drops the flags again, and after a fresh reset a low power input leaves the flags high.
- R10: After a power-down, an output whose software or pin enable went low meanwhile stays stopped when power returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock to be distributed |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_n | input | 1 | Power-good qualifier, then active-low power-down (asynchronous) |
| hw_oe | input | 6 | Hardware enable pins (asynchronous) |
| sw_oe | input | 9 | Software enable bits, one per output |
| clk_out | output | 9 | Gated clock outputs |
| osc_run | output | 1 | High when the oscillator should run |
| ser_run | output | 1 | High when the serial control logic should run |

## Verification
The outputs are driven with all enables high, with a mixed software mask, with each shared pin lowered on its own, and with a single solo pin toggled. Comparing pulse counts across these patterns separates a wrong pin-to-output map from a missing AND term. The power input is walked through its qualifier phase, a first power-down, a restart with one enable changed while down, a second power-down and a fresh reset. That sequence tells a sticky armed flag apart from one that follows the pin. Pulse widths and first-edge times are measured on every output, so truncated pulses and late restarts are caught.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int SOLO_OUTS = 4;
  localparam int GRP_A_OUTS = 2;
  localparam int GRP_B_OUTS = 3;
  localparam int SYNC_STAGES = 2;

  // Pin index serving a given output: solo pins first, then the pair, then the trio.
  function automatic int pin_of(input int idx, input int solo, input int grp_a);
    if (idx < solo) return idx;
    else if (idx < solo + grp_a) return solo;
    else return solo + 1;
  endfunction
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cg_power.sv
module cg_power (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_s,
  output logic allow,
  output logic armed,
  output logic osc_run,
  output logic ser_run
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q | pg_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // Outputs need the synchronized pin high in both phases; the flags only
  // fall once the pin has been seen high.
  assign allow   = pg_s;
  assign armed   = armed_q;
  assign osc_run = ~armed_q | pg_s;
  assign ser_run = ~armed_q | pg_s;
endmodule

// File: rtl/cg_gate.sv
module cg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  output logic en,
  output logic clk_gated
);
  logic en_q;

  // Enable moves only on the falling edge, while the clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= want;
  end

  assign en        = en_q;
  assign clk_gated = clk & en_q;
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl #(
  parameter int SOLO  = clkgate_pkg::SOLO_OUTS,
  parameter int GRP_A = clkgate_pkg::GRP_A_OUTS,
  parameter int GRP_B = clkgate_pkg::GRP_B_OUTS,
  parameter int SYNC  = clkgate_pkg::SYNC_STAGES
) (
  input  logic                          clk_ref,
  input  logic                          rst_n,
  input  logic                          pwr_n,
  input  logic [SOLO+1:0]               hw_oe,
  input  logic [SOLO+GRP_A+GRP_B-1:0]   sw_oe,
  output logic [SOLO+GRP_A+GRP_B-1:0]   clk_out,
  output logic                          osc_run,
  output logic                          ser_run
);
  localparam int NOUT = SOLO + GRP_A + GRP_B;
  localparam int NPIN = SOLO + 2;

  logic [1:0]      rst_pipe;
  logic            rst_q;
  logic [NPIN-1:0] pin_s;
  logic            pg_s;
  logic            allow;
  logic            armed;
  logic [NOUT-1:0] want;
  logic [NOUT-1:0] gate_en;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  cg_sync #(.W(NPIN), .STAGES(SYNC)) u_pin_sync (
    .clk(clk_ref), .rst_n(rst_q), .d(hw_oe), .q(pin_s)
  );

  cg_sync #(.W(1), .STAGES(SYNC)) u_pwr_sync (
    .clk(clk_ref), .rst_n(rst_q), .d(pwr_n), .q(pg_s)
  );

  cg_power u_power (
    .clk(clk_ref), .rst_n(rst_q), .pg_s(pg_s), .allow(allow),
    .armed(armed), .osc_run(osc_run), .ser_run(ser_run)
  );

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    localparam int P = clkgate_pkg::pin_of(i, SOLO, GRP_A);
    assign want[i] = allow & pin_s[P] & sw_oe[i];
    cg_gate u_gate (
      .clk(clk_ref), .rst_n(rst_q), .want(want[i]),
      .en(gate_en[i]), .clk_gated(clk_out[i])
    );
  end
endmodule

// File: rtl/cg_checker.sv
module cg_checker #(
  parameter int SOLO  = 4,
  parameter int GRP_A = 2,
  parameter int NOUT  = 9,
  parameter int NPIN  = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pg_s,
  input logic            armed,
  input logic [NPIN-1:0] pin_s,
  input logic [NOUT-1:0] gate_en
);
  // R9: armed state is sticky until reset
  assert_armed_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  // R6: arming only follows a high sample of the power input
  assert_arm_on_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(pg_s));

  // R7: with the synchronized power input low no gate is open
  assert_off_when_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |-> (gate_en == '0));

  for (genvar i = 0; i < NOUT; i++) begin : g_chk
    localparam int P = clkgate_pkg::pin_of(i, SOLO, GRP_A);
    // R2 / R3: an open gate implies its mapped pin is high
    assert_pin_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en[i] |-> pin_s[P]);
  end
endmodule

bind clk_gate_ctrl cg_checker #(
  .SOLO(SOLO), .GRP_A(GRP_A), .NOUT(NOUT), .NPIN(NPIN)
) u_cg_checker (
  .clk(clk_ref), .rst_n(rst_q), .pg_s(pg_s), .armed(armed),
  .pin_s(pin_s), .gate_en(gate_en)
);

// File: tb/test_clk_gate_ctrl.sv
module test_clk_gate_ctrl;
  localparam int N = 9;

  logic         clk_ref = 1'b0;
  logic         rst_n;
  logic         pwr_n;
  logic [5:0]   hw_oe;
  logic [N-1:0] sw_oe;
  logic [N-1:0] clk_out;
  logic         osc_run, ser_run;

  int checks = 0;
  int errors = 0;

  int    cnt     [N];
  bit    armed_r [N];
  time   rise_t  [N];
  bit    got_1st [N];
  time   first_t [N];
  int    bad_pulse = 0;

  always #5 clk_ref = ~clk_ref;

  clk_gate_ctrl i_clk_gate_ctrl (
    .clk_ref(clk_ref), .rst_n(rst_n), .pwr_n(pwr_n), .hw_oe(hw_oe),
    .sw_oe(sw_oe), .clk_out(clk_out), .osc_run(osc_run), .ser_run(ser_run)
  );

  for (genvar g = 0; g < N; g++) begin : g_mon
    always @(posedge clk_out[g]) begin
      cnt[g]++;
      rise_t[g]  = $time;
      armed_r[g] = 1'b1;
      if (!got_1st[g]) begin
        got_1st[g] = 1'b1;
        first_t[g] = $time;
      end
    end
    always @(negedge clk_out[g]) begin
      if (armed_r[g] && ($time - rise_t[g] != 5)) bad_pulse++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_ref);
    #1;
  endtask

  task automatic window(input int n);
    for (int k = 0; k < N; k++) cnt[k] = 0;
    step(n);
  endtask

  task automatic arm_first();
    for (int k = 0; k < N; k++) got_1st[k] = 1'b0;
  endtask

  // Cycles from t0 to first rise of output k; 99 when none.
  function automatic int lat_cycles(input int k, input time t0);
    if (!got_1st[k]) return 99;
    return int'((first_t[k] - t0 + 1) / 10);
  endfunction

  task automatic chk_counts(input string req, input logic [N-1:0] exp_run, input int n);
    window(n);
    for (int k = 0; k < N; k++) chk(req, cnt[k], exp_run[k] ? n : 0);
  endtask

  task automatic chk_idle_low(input string req, input logic [N-1:0] exp_run);
    @(posedge clk_ref); #2;
    for (int k = 0; k < N; k++)
      if (!exp_run[k]) chk(req, int'(clk_out[k]), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwr_n = 1'b0; hw_oe = '1; sw_oe = '1;
    step(3);
    chk("R1 out in reset", int'(clk_out), 0);
    rst_n = 1'b1;
    step(4);
    chk("R1 osc_run", int'(osc_run), 1);
    chk("R1 ser_run", int'(ser_run), 1);
    chk_counts("R6 no pulses before power-good", '0, 8);
    chk("R6 osc_run still high", int'(osc_run), 1);
  endtask

  task automatic t_power_good();
    time t0;
    arm_first();
    pwr_n = 1'b1; t0 = $time;
    step(8);
    chk("R8 first start >=2", int'(lat_cycles(0, t0) >= 2), 1);
    chk("R8 first start <=6", int'(lat_cycles(0, t0) <= 6), 1);
    chk_counts("R2 all enables high", '1, 10);
  endtask

  task automatic t_sw_mask();
    sw_oe = 9'b1_0110_1001;
    step(6);
    chk_counts("R2 software mask", 9'b1_0110_1001, 10);
    chk_idle_low("R4 stopped rests low", 9'b1_0110_1001);
    sw_oe = '1;
    step(6);
  endtask

  task automatic t_groups();
    hw_oe = 6'b101111;
    step(6);
    chk_counts("R3 pair pin low", 9'b1_1100_1111, 10);
    hw_oe = 6'b011111;
    step(6);
    chk_counts("R3 trio pin low", 9'b0_0011_1111, 10);
    hw_oe = '1;
    step(6);
  endtask

  task automatic t_solo_pin();
    time t0;
    hw_oe[2] = 1'b0;
    step(6);
    chk_counts("R3 solo pin low", 9'b1_1111_1011, 10);
    arm_first();
    hw_oe[2] = 1'b1; t0 = $time;
    step(8);
    chk("R5 restart >=2", int'(lat_cycles(2, t0) >= 2), 1);
    chk("R5 restart <=6", int'(lat_cycles(2, t0) <= 6), 1);
  endtask

  task automatic t_power_down();
    time t0;
    pwr_n = 1'b0;
    step(3);
    chk("R7 osc_run drops", int'(osc_run), 0);
    chk("R7 ser_run drops", int'(ser_run), 0);
    chk_counts("R7 all stopped", '0, 8);
    chk_idle_low("R4 down rests low", '0);
    sw_oe[3] = 1'b0;
    hw_oe[4] = 1'b0;
    step(2);
    arm_first();
    pwr_n = 1'b1; t0 = $time;
    step(8);
    chk("R8 flags back", int'(osc_run & ser_run), 1);
    chk("R8 restart >=2", int'(lat_cycles(0, t0) >= 2), 1);
    chk("R8 restart <=6", int'(lat_cycles(0, t0) <= 6), 1);
    chk_counts("R10 disabled outputs stay off", 9'b1_1100_0111, 10);
    sw_oe = '1; hw_oe = '1;
    step(6);
  endtask

  task automatic t_second_down();
    pwr_n = 1'b0;
    step(3);
    chk("R9 second down flags", int'(osc_run | ser_run), 0);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(5);
    chk("R9 reset clears armed", int'(osc_run & ser_run), 1);
    chk_counts("R9 outputs off after reset", '0, 6);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      cnt[k] = 0; armed_r[k] = 1'b0; got_1st[k] = 1'b0;
      rise_t[k] = 0; first_t[k] = 0;
    end
    t_reset();
    t_power_good();
    t_sw_mask();
    t_groups();
    t_solo_pin();
    t_power_down();
    t_second_down();
    chk("R4 pulse widths", bad_pulse, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule